// File: doc/BRIEF.md
# MDIO link state resolver

This block works out the current state of an Ethernet link by reading management registers of an attached transceiver. It uses a simple read-request interface towards an MDIO master. A one-cycle start pulse, together with a copper/fibre mode input, begins a pass. The sequencer then issues a chain of register reads. Which read comes next depends on the values already returned.

When the pass ends, the block publishes several results from registered outputs:
- link-up state,
- a speed code,
- duplex with a known/unknown qualifier,
- receive and transmit pause flags.

A one-cycle result-valid pulse marks each update. A failed read aborts the pass. It raises the error flag and leaves the last published result untouched.

Serial framing on the management bus, the negotiation procedure itself and all register writes are done elsewhere. The block only orders the reads and decodes them. The link bit is latched low in the device, so a reported link-down is always read a second time. The source of speed and duplex depends on whether auto-negotiation is on and finished. Pause is resolved from the partner and local abilities, using a copper bit layout or a fibre bit layout.

Top module: `link_resolver`

## Requirements
- R1: A pass accepted by start reads register 0 (control) and then register 1 (status). A read holds request and address steady until done. A read that returns with the error input set ends the pass at once: error goes to 1, no result-valid pulse follows and all result outputs keep their previous values. Error returns to 0 when the next pass is accepted.
- R2: Status bit 2 is the link bit. If the first status read shows it at 0, register 1 is read a second time. Link-up and the completion bit are then taken from that second value.
- R3: When control bit 12 (auto-negotiation enable) is 0, duplex is control bit 8 (1 = full) and known. Speed is 1000 when control bit 6 is set, else 100 when control bit 13 is set, else 10. No further reads follow, and pause is none.
- R4: In copper mode, with control bit 12 set and status bit 5 (negotiation complete) set, register 28 is read next. Duplex is its bit 5. Its bits 4:3 decode as 0 → 10, 1 → 100, and 2 or 3 → 1000.
- R5: Pause is resolved only for a full-duplex result, by reading register 5 (partner) and then register 4 (local). If both sides show symmetric pause, both the receive and transmit pause flags are set. When copper duplex is half, registers 5 and 4 are not read and pause is none.
- R6: In copper mode, symmetric pause is bit 10 and asymmetric pause is bit 11. Without common symmetric pause, the result is as follows:
  - transmit-only when the partner has both bits and local has bit 11;
  - receive-only when the partner has bit 11 and local has bit 10;
  - otherwise none.
- R7: In fibre mode, with negotiation complete, registers 5 then 4 are always read. Bit 5 common to both gives 1000 full duplex. Otherwise bit 6 common to both gives 1000 half duplex. Otherwise speed and duplex are unknown. The pause rules of R5 and R6 apply with symmetric pause at bit 7 and asymmetric pause at bit 8, for full duplex only.
- R8: When auto-negotiation is enabled but status bit 5 is 0, the pass ends after the status reads. Speed is reported unknown, duplex unknown and pause none.
- R9: The speed output uses 00 = 10, 01 = 100, 10 = 1000 and 11 = unknown. duplex_known is 0 exactly when the speed is unknown, and duplex_full is then 0.
- R10: A start pulse that arrives while a pass is running is ignored. Each successful pass gives exactly one result-valid pulse, one cycle long, and the outputs update in that cycle.
- R11: After reset, no read is requested. Link-up, duplex, duplex_known, the pause flags, result-valid and error are 0, and speed is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (honoured only when idle) |
| fiber_mode | input | 1 | 1 = fibre ability layout, 0 = copper; sampled at start |
| mdio_req | output | 1 | Read request, held until done |
| mdio_addr | output | 5 | Register address of the pending read |
| mdio_rdata | input | 16 | Read data, valid with done |
| mdio_done | input | 1 | Read completed (one cycle) |
| mdio_err | input | 1 | Read failed, valid with done |
| link_ok | output | 1 | Link is up |
| speed | output | 2 | Speed code (00=10, 01=100, 10=1000, 11=unknown) |
| duplex_full | output | 1 | Full duplex |
| duplex_known | output | 1 | Duplex value is meaningful |
| pause_rx | output | 1 | Honour received pause frames |
| pause_tx | output | 1 | Send pause frames |
| result_valid | output | 1 | One-cycle pulse when results update |
| error | output | 1 | Last pass aborted on a read error |

## Verification
A sequencer that takes a wrong branch shows up on the read interface first. It issues an address that is out of order or unneeded, or it stops reading early. The bench records every address served and compares the sequence with the expected chain when the pass ends.

A wrong captured or decoded value shows up in the outputs during the single result-valid cycle that ends the pass. A lost or doubled pass shows up as a missing or repeated pulse, within a few cycles of the final read.

Error injection at each position checks that the outputs stay frozen. It also checks that the error flag clears on the next accepted start.

// File: rtl/link_res_pkg.sv
package link_res_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] ADDR_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] ADDR_LPA  = 5'd5;
    localparam logic [ADDR_W-1:0] ADDR_AUX  = 5'd28;

    localparam int CTRL_SPD100 = 13;
    localparam int CTRL_ANEN   = 12;
    localparam int CTRL_FDX    = 8;
    localparam int CTRL_SPD1G  = 6;
    localparam int STAT_LINK   = 2;
    localparam int STAT_ANC    = 5;
    localparam int AUX_FDX     = 5;
    localparam int AUX_SPD_LO  = 3;
    localparam int CU_PAUSE    = 10;
    localparam int CU_ASYM     = 11;
    localparam int FX_FULL     = 5;
    localparam int FX_HALF     = 6;
    localparam int FX_PAUSE    = 7;
    localparam int FX_ASYM     = 8;

    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10,
        SPD_UNK  = 2'b11
    } speed_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CTRL, ST_STAT, ST_STAT2, ST_AUX, ST_LPA, ST_ADV, ST_FIN
    } state_e;

    typedef struct packed {
        logic an_en;
        logic fdx;
        logic spd1g;
        logic spd100;
    } ctrl_bits_t;

    typedef struct packed {
        logic cu_pause;
        logic cu_asym;
        logic fx_full;
        logic fx_half;
        logic fx_pause;
        logic fx_asym;
    } abil_t;

    typedef struct packed {
        logic   link_ok;
        speed_e speed;
        logic   dup_full;
        logic   dup_known;
        logic   pause_rx;
        logic   pause_tx;
    } link_result_t;

    localparam link_result_t RESULT_RESET = '{
        link_ok: 1'b0, speed: SPD_UNK, dup_full: 1'b0,
        dup_known: 1'b0, pause_rx: 1'b0, pause_tx: 1'b0};

    // {rx, tx} from partner / local symmetric and asymmetric bits
    function automatic logic [1:0] resolve_pause(input logic lp_sym, input logic lp_asym,
                                                 input logic lo_sym, input logic lo_asym);
        if (lp_sym && lo_sym)                 return 2'b11;
        else if (lp_sym && lp_asym && lo_asym) return 2'b01;
        else if (lp_asym && lo_sym)           return 2'b10;
        else                                  return 2'b00;
    endfunction

    function automatic speed_e aux_speed(input logic [1:0] code);
        case (code)
            2'd0:    return SPD_10;
            2'd1:    return SPD_100;
            default: return SPD_1000;
        endcase
    endfunction

endpackage

// File: rtl/link_res_seq.sv
module link_res_seq
    import link_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fiber_mode,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  rd_data,
    input  logic              rd_done,
    input  logic              rd_err,
    output logic              start_acc,
    output logic              abort,
    output logic              fin,
    output ctrl_bits_t        ctrl_q,
    output logic              link_q,
    output logic              ancmp_q,
    output logic              aux_fdx_q,
    output logic [1:0]        aux_spd_q,
    output abil_t             lpa_q,
    output abil_t             adv_q,
    output logic              fiber_q
);

    state_e     state;
    state_e     after_status;
    ctrl_bits_t rd_ctrl;
    abil_t      rd_abil;
    logic       unused_rdata;
    logic       ok_done;

    assign unused_rdata = ^rd_data;
    assign rd_req    = (state != ST_IDLE) && (state != ST_FIN);
    assign start_acc = start && (state == ST_IDLE);
    assign abort     = rd_req && rd_done && rd_err;
    assign ok_done   = rd_req && rd_done && !rd_err;
    assign fin       = (state == ST_FIN);

    always_comb begin
        rd_ctrl.an_en    = rd_data[CTRL_ANEN];
        rd_ctrl.fdx      = rd_data[CTRL_FDX];
        rd_ctrl.spd1g    = rd_data[CTRL_SPD1G];
        rd_ctrl.spd100   = rd_data[CTRL_SPD100];
        rd_abil.cu_pause = rd_data[CU_PAUSE];
        rd_abil.cu_asym  = rd_data[CU_ASYM];
        rd_abil.fx_full  = rd_data[FX_FULL];
        rd_abil.fx_half  = rd_data[FX_HALF];
        rd_abil.fx_pause = rd_data[FX_PAUSE];
        rd_abil.fx_asym  = rd_data[FX_ASYM];
        if (!ctrl_q.an_en || !rd_data[STAT_ANC]) after_status = ST_FIN;
        else if (fiber_q)                        after_status = ST_LPA;
        else                                     after_status = ST_AUX;
    end

    always_comb begin
        case (state)
            ST_CTRL:          rd_addr = ADDR_CTRL;
            ST_STAT, ST_STAT2: rd_addr = ADDR_STAT;
            ST_AUX:           rd_addr = ADDR_AUX;
            ST_LPA:           rd_addr = ADDR_LPA;
            ST_ADV:           rd_addr = ADDR_ADV;
            default:          rd_addr = ADDR_CTRL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctrl_q    <= '0;
            link_q    <= 1'b0;
            ancmp_q   <= 1'b0;
            aux_fdx_q <= 1'b0;
            aux_spd_q <= '0;
            lpa_q     <= '0;
            adv_q     <= '0;
            fiber_q   <= 1'b0;
        end else if (abort) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_CTRL;
                    fiber_q <= fiber_mode;
                end
                ST_CTRL: if (ok_done) begin
                    ctrl_q <= rd_ctrl;
                    state  <= ST_STAT;
                end
                ST_STAT, ST_STAT2: if (ok_done) begin
                    link_q  <= rd_data[STAT_LINK];
                    ancmp_q <= rd_data[STAT_ANC];
                    if (state == ST_STAT && !rd_data[STAT_LINK]) state <= ST_STAT2;
                    else                                          state <= after_status;
                end
                ST_AUX: if (ok_done) begin
                    aux_fdx_q <= rd_data[AUX_FDX];
                    aux_spd_q <= rd_data[AUX_SPD_LO +: 2];
                    state     <= rd_data[AUX_FDX] ? ST_LPA : ST_FIN;
                end
                ST_LPA: if (ok_done) begin
                    lpa_q <= rd_abil;
                    state <= ST_ADV;
                end
                ST_ADV: if (ok_done) begin
                    adv_q <= rd_abil;
                    state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_done |=> rd_req && $stable(rd_addr));

    assert_start_ctrl_R1: assert property (@(posedge clk) disable iff (rst)
        start_acc |=> rd_req && rd_addr == ADDR_CTRL);

    assert_ctrl_then_stat_R1: assert property (@(posedge clk) disable iff (rst)
        ok_done && rd_addr == ADDR_CTRL |=> rd_req && rd_addr == ADDR_STAT);

    assert_reread_R2: assert property (@(posedge clk) disable iff (rst)
        ok_done && state == ST_STAT && !rd_data[STAT_LINK] |=> rd_req && rd_addr == ADDR_STAT);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req && start && !rd_done |=> rd_req && $stable(rd_addr));

endmodule

// File: rtl/link_res_decode.sv
module link_res_decode
    import link_res_pkg::*;
(
    input  ctrl_bits_t   ctrl_q,
    input  logic         link_q,
    input  logic         ancmp_q,
    input  logic         aux_fdx_q,
    input  logic [1:0]   aux_spd_q,
    input  abil_t        lpa_q,
    input  abil_t        adv_q,
    input  logic         fiber_q,
    output link_result_t res
);

    abil_t      common;
    logic [1:0] pz;

    assign common = lpa_q & adv_q;

    always_comb begin
        res         = RESULT_RESET;
        res.link_ok = link_q;
        pz          = 2'b00;
        if (!ctrl_q.an_en) begin
            res.dup_known = 1'b1;
            res.dup_full  = ctrl_q.fdx;
            res.speed     = ctrl_q.spd1g ? SPD_1000 : (ctrl_q.spd100 ? SPD_100 : SPD_10);
        end else if (ancmp_q) begin
            if (fiber_q) begin
                if (common.fx_full || common.fx_half) begin
                    res.speed     = SPD_1000;
                    res.dup_known = 1'b1;
                    res.dup_full  = common.fx_full;
                end
                pz = resolve_pause(lpa_q.fx_pause, lpa_q.fx_asym,
                                   adv_q.fx_pause, adv_q.fx_asym);
            end else begin
                res.speed     = aux_speed(aux_spd_q);
                res.dup_known = 1'b1;
                res.dup_full  = aux_fdx_q;
                pz = resolve_pause(lpa_q.cu_pause, lpa_q.cu_asym,
                                   adv_q.cu_pause, adv_q.cu_asym);
            end
            if (res.dup_full) begin
                res.pause_rx = pz[1];
                res.pause_tx = pz[0];
            end
        end
    end

endmodule

// File: rtl/link_resolver.sv
module link_resolver
    import link_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fiber_mode,
    output logic              mdio_req,
    output logic [ADDR_W-1:0] mdio_addr,
    input  logic [REG_W-1:0]  mdio_rdata,
    input  logic              mdio_done,
    input  logic              mdio_err,
    output logic              link_ok,
    output logic [1:0]        speed,
    output logic              duplex_full,
    output logic              duplex_known,
    output logic              pause_rx,
    output logic              pause_tx,
    output logic              result_valid,
    output logic              error
);

    ctrl_bits_t   ctrl_q;
    logic         link_q, ancmp_q, aux_fdx_q, fiber_q;
    logic [1:0]   aux_spd_q;
    abil_t        lpa_q, adv_q;
    logic         start_acc, abort, fin;
    link_result_t dec, result_q;
    logic         valid_q, err_q;

    link_res_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .fiber_mode(fiber_mode),
        .rd_req(mdio_req), .rd_addr(mdio_addr), .rd_data(mdio_rdata),
        .rd_done(mdio_done), .rd_err(mdio_err),
        .start_acc(start_acc), .abort(abort), .fin(fin),
        .ctrl_q(ctrl_q), .link_q(link_q), .ancmp_q(ancmp_q),
        .aux_fdx_q(aux_fdx_q), .aux_spd_q(aux_spd_q),
        .lpa_q(lpa_q), .adv_q(adv_q), .fiber_q(fiber_q)
    );

    link_res_decode u_dec (
        .ctrl_q(ctrl_q), .link_q(link_q), .ancmp_q(ancmp_q),
        .aux_fdx_q(aux_fdx_q), .aux_spd_q(aux_spd_q),
        .lpa_q(lpa_q), .adv_q(adv_q), .fiber_q(fiber_q), .res(dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= RESULT_RESET;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            valid_q <= fin;
            if (fin) result_q <= dec;
            if (abort)          err_q <= 1'b1;
            else if (start_acc) err_q <= 1'b0;
        end
    end

    assign link_ok      = result_q.link_ok;
    assign speed        = result_q.speed;
    assign duplex_full  = result_q.dup_full;
    assign duplex_known = result_q.dup_known;
    assign pause_rx     = result_q.pause_rx;
    assign pause_tx     = result_q.pause_tx;
    assign result_valid = valid_q;
    assign error        = err_q;

    assert_abort_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        abort |=> !result_valid && error && $stable(result_q));

    assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    assert_unknown_pair_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> ((speed == SPD_UNK) == !duplex_known) && (duplex_known || !duplex_full));

    assert_pause_fdx_R5: assert property (@(posedge clk) disable iff (rst)
        result_valid && (pause_rx || pause_tx) |-> duplex_full && duplex_known);

endmodule

// File: tb/link_resolver_test.sv
module link_resolver_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        fiber_mode = 1'b0;
    logic        mdio_req;
    logic [4:0]  mdio_addr;
    logic [15:0] mdio_rdata = '0;
    logic        mdio_done = 1'b0;
    logic        mdio_err = 1'b0;
    logic        link_ok, duplex_full, duplex_known, pause_rx, pause_tx;
    logic        result_valid, error;
    logic [1:0]  speed;

    always #10 clk = ~clk;

    link_resolver uut (
        .clk(clk), .rst(rst), .start(start), .fiber_mode(fiber_mode),
        .mdio_req(mdio_req), .mdio_addr(mdio_addr), .mdio_rdata(mdio_rdata),
        .mdio_done(mdio_done), .mdio_err(mdio_err),
        .link_ok(link_ok), .speed(speed), .duplex_full(duplex_full),
        .duplex_known(duplex_known), .pause_rx(pause_rx), .pause_tx(pause_tx),
        .result_valid(result_valid), .error(error)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // register image served by the slave model
    logic [15:0] r_ctrl, r_s1, r_s2, r_aux, r_lpa, r_adv;
    int          err_addr = -1;
    int          lat = 1;
    int          seq_q[$];
    int          stat_reads = 0;
    int          cnt = 0;

    // monitor state
    bit pass_open = 0;
    int rv_count = 0;
    bit prev_rv = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // slave: answers a held request after lat cycles with a one-cycle done
    always @(negedge clk) begin
        if (mdio_done) begin
            mdio_done = 1'b0;
            mdio_err  = 1'b0;
            cnt = 0;
        end else if (!rst && mdio_req) begin
            if (cnt >= lat) begin
                int a;
                a = int'(mdio_addr);
                seq_q.push_back(a);
                case (a)
                    0:  mdio_rdata = r_ctrl;
                    1:  begin mdio_rdata = (stat_reads == 0) ? r_s1 : r_s2; stat_reads++; end
                    28: mdio_rdata = r_aux;
                    5:  mdio_rdata = r_lpa;
                    4:  mdio_rdata = r_adv;
                    default: mdio_rdata = 16'hdead;
                endcase
                mdio_err  = (a == err_addr);
                mdio_done = 1'b1;
            end else begin
                cnt++;
            end
        end
    end

    // per-clock protocol checks on the result pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (result_valid && prev_rv) chk("R10 pulse longer than one cycle", 1, 0);
            if (result_valid && !pass_open) chk("R10 pulse outside a pass", 1, 0);
            if (result_valid) rv_count++;
            if (mdio_req && !pass_open) chk("R1 request outside a pass", 1, 0);
        end
        prev_rv = result_valid;
    end

    // behavioural expectation
    int e_seq[$];
    int e_link, e_spd, e_fd, e_kn, e_rx, e_tx;

    task automatic model(input bit fib);
        logic [15:0] st, c;
        int psym_lp, pasy_lp, psym_lo, pasy_lo, f;
        e_seq = {};
        e_seq.push_back(0);
        e_seq.push_back(1);
        st = r_s1;
        if (r_s1[2] == 1'b0) begin e_seq.push_back(1); st = r_s2; end
        e_link = st[2];
        e_rx = 0; e_tx = 0;
        psym_lp = 0; pasy_lp = 0; psym_lo = 0; pasy_lo = 0;
        if (r_ctrl[12] == 1'b0) begin
            e_kn = 1; e_fd = r_ctrl[8];
            if (r_ctrl[6]) e_spd = 2; else if (r_ctrl[13]) e_spd = 1; else e_spd = 0;
        end else if (st[5] == 1'b0) begin
            e_kn = 0; e_fd = 0; e_spd = 3;
        end else if (fib) begin
            e_seq.push_back(5); e_seq.push_back(4);
            c = r_lpa & r_adv;
            if (c[5])      begin e_spd = 2; e_fd = 1; e_kn = 1; end
            else if (c[6]) begin e_spd = 2; e_fd = 0; e_kn = 1; end
            else           begin e_spd = 3; e_fd = 0; e_kn = 0; end
            psym_lp = r_lpa[7]; pasy_lp = r_lpa[8]; psym_lo = r_adv[7]; pasy_lo = r_adv[8];
        end else begin
            e_seq.push_back(28);
            e_fd = r_aux[5]; e_kn = 1;
            f = int'(r_aux[4:3]);
            e_spd = (f == 0) ? 0 : (f == 1) ? 1 : 2;
            if (e_fd == 1) begin e_seq.push_back(5); e_seq.push_back(4); end
            psym_lp = r_lpa[10]; pasy_lp = r_lpa[11]; psym_lo = r_adv[10]; pasy_lo = r_adv[11];
        end
        if (e_fd == 1 && e_kn == 1 && r_ctrl[12] && st[5]) begin
            if (psym_lp && psym_lo) begin e_rx = 1; e_tx = 1; end
            else if (psym_lp && pasy_lp && pasy_lo) e_tx = 1;
            else if (pasy_lp && psym_lo) e_rx = 1;
        end
        if (err_addr >= 0) begin
            int k[$];
            foreach (e_seq[i]) begin
                k.push_back(e_seq[i]);
                if (e_seq[i] == err_addr) break;
            end
            e_seq = k;
        end
    endtask

    task automatic run_pass(string tag, bit fib, bit busy_start);
        int waited;
        int p_link, p_spd, p_fd, p_kn, p_rx, p_tx;
        bit seq_ok;
        bit expect_err;
        model(fib);
        expect_err = 0;
        foreach (e_seq[i]) if (e_seq[i] == err_addr) expect_err = 1;
        p_link = link_ok; p_spd = speed; p_fd = duplex_full; p_kn = duplex_known;
        p_rx = pause_rx; p_tx = pause_tx;
        seq_q = {};
        stat_reads = 0;
        rv_count = 0;
        pass_open = 1;
        @(negedge clk);
        fiber_mode = fib;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R1 error cleared on start"}, int'(error), 0);
        if (busy_start) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            fiber_mode = ~fib;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!result_valid && !error && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 2000) chk({tag, " pass timeout"}, 1, 0);
        seq_ok = (seq_q.size() == e_seq.size());
        if (seq_ok) foreach (e_seq[i]) if (seq_q[i] != e_seq[i]) seq_ok = 0;
        chk({tag, " R1 read sequence"}, int'(seq_ok), 1);
        if (!seq_ok) begin
            foreach (seq_q[i]) $display("  got addr %0d", seq_q[i]);
            foreach (e_seq[i]) $display("  exp addr %0d", e_seq[i]);
        end
        if (expect_err) begin
            chk({tag, " R1 error flag"}, int'(error), 1);
            chk({tag, " R1 link frozen"}, int'(link_ok), p_link);
            chk({tag, " R1 speed frozen"}, int'(speed), p_spd);
            chk({tag, " R1 duplex frozen"}, int'(duplex_full), p_fd);
            chk({tag, " R1 known frozen"}, int'(duplex_known), p_kn);
            chk({tag, " R1 pause frozen"}, int'({pause_rx, pause_tx}), (p_rx << 1) | p_tx);
        end else begin
            chk({tag, " R2 link_ok"}, int'(link_ok), e_link);
            chk({tag, " R9 speed code"}, int'(speed), e_spd);
            chk({tag, " R3/R4 duplex"}, int'(duplex_full), e_fd);
            chk({tag, " R9 duplex_known"}, int'(duplex_known), e_kn);
            chk({tag, " R5/R6 pause_rx"}, int'(pause_rx), e_rx);
            chk({tag, " R5/R6 pause_tx"}, int'(pause_tx), e_tx);
        end
        repeat (8) @(negedge clk);
        chk({tag, " R10 result pulse count"}, rv_count, expect_err ? 0 : 1);
        pass_open = 0;
    endtask

    task automatic setregs(logic [15:0] c, logic [15:0] s1, logic [15:0] s2,
                           logic [15:0] ax, logic [15:0] lp, logic [15:0] ad);
        r_ctrl = c; r_s1 = s1; r_s2 = s2; r_aux = ax; r_lpa = lp; r_adv = ad;
    endtask

    localparam logic [15:0] AN  = 16'h1000;
    localparam logic [15:0] LNK = 16'h0004;
    localparam logic [15:0] ANC = 16'h0020;

    initial begin
        setregs(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 req", int'(mdio_req), 0);
        chk("R11 speed", int'(speed), 3);
        chk("R11 link/dup/known", int'({link_ok, duplex_full, duplex_known}), 0);
        chk("R11 pause", int'({pause_rx, pause_tx}), 0);
        chk("R11 valid/error", int'({result_valid, error}), 0);

        // R3 forced 100 full, link up
        lat = 1;
        setregs(16'h2100, LNK, LNK, 0, 16'h0400, 16'h0400);
        run_pass("forced100", 0, 0);
        // R3 1000 select wins over 100, half; R2 latch-low re-read
        lat = 3;
        setregs(16'h2040, 0, LNK, 0, 0, 0);
        run_pass("forced1000", 0, 0);
        // R3 forced 10, link stays down
        lat = 0;
        setregs(16'h0100, 0, 0, 0, 0, 0);
        run_pass("forced10", 0, 0);
        // R4 R5 copper aux code 3 -> 1000 full, symmetric pause
        lat = 2;
        setregs(AN, LNK | ANC, 0, 16'h0038, 16'h0400, 16'h0c00);
        run_pass("cu_sym", 0, 0);
        // R4 R5 copper 100 half: no pause reads
        setregs(AN, LNK | ANC, 0, 16'h0008, 16'h0c00, 16'h0c00);
        run_pass("cu_half", 0, 0);
        // R6 tx-only
        setregs(AN, LNK | ANC, 0, 16'h0030, 16'h0c00, 16'h0800);
        run_pass("cu_tx", 0, 0);
        // R6 rx-only, aux code 0 -> 10
        setregs(AN, LNK | ANC, 0, 16'h0020, 16'h0800, 16'h0400);
        run_pass("cu_rx", 0, 0);
        // R6 none: partner sym only, local asym only
        setregs(AN, LNK | ANC, 0, 16'h0030, 16'h0400, 16'h0800);
        run_pass("cu_none", 0, 0);
        // R8 negotiation incomplete
        setregs(AN, LNK, LNK, 16'h0038, 16'h0c00, 16'h0c00);
        run_pass("an_pending", 0, 0);
        // R2 completion bit from second status read
        setregs(AN, 0, LNK | ANC, 16'h0028, 0, 0);
        run_pass("cu_reread", 0, 0);
        // R7 fibre full with symmetric pause
        setregs(AN, LNK | ANC, 0, 0, 16'h00a0, 16'h00e0);
        run_pass("fx_full", 1, 0);
        // R7 fibre half only, pause bits ignored
        setregs(AN, LNK | ANC, 0, 0, 16'h01c0, 16'h01c0);
        run_pass("fx_half", 1, 0);
        // R7 fibre unresolved -> unknown
        setregs(AN, LNK | ANC, 0, 0, 16'h0020, 16'h0040);
        run_pass("fx_unres", 1, 0);
        // R7 fibre tx-only
        setregs(AN, LNK | ANC, 0, 0, 16'h01a0, 16'h0120);
        run_pass("fx_tx", 1, 0);
        // R1 error on status read, then on control, then on a late read
        err_addr = 1;
        setregs(16'h2100, 0, LNK, 0, 0, 0);
        run_pass("err_stat", 0, 0);
        err_addr = 0;
        run_pass("err_ctrl", 0, 0);
        err_addr = 4;
        setregs(AN, LNK | ANC, 0, 16'h0038, 16'h0400, 16'h0400);
        run_pass("err_adv", 0, 0);
        err_addr = -1;
        // R10 start during a running pass ignored
        lat = 6;
        setregs(AN, LNK | ANC, 0, 16'h0038, 16'h0c00, 16'h0800);
        run_pass("busy_start", 0, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule